// File: doc/BRIEF.md
# Endpoint Buffer Ownership Switch

This block manages a shared pool of equal-sized packet buffers, eight by default, each 256 words of 16 bits. The buffers pass between a USB packet-engine domain and a local I/O domain. A configuration load gives each endpoint a chain of zero to four buffers, taken from the pool in endpoint order. Each endpoint also gets a direction that says which domain fills its buffers. When the producing domain commits a buffer, the consuming domain becomes its owner. When the consuming domain releases it, the buffer goes back to the producer. Only ownership changes and no data is copied, so the buffer index each side presents is used straight as the upper address bits of the shared RAM.

Within an endpoint, buffers are handed over in strict round-robin order. The consumer therefore sees them in commit order. Each endpoint reports empty to its consumer and full to its producer. A per-buffer bitmap shows which domain holds every buffer at any moment.

Top module: `bufsw_top`

## Requirements
- R1: After reset every endpoint has depth 0, all bits of `epEmpty` and `epFull` are 1, every buffer index is 0, `bufIoOwned` is all 0 and `cfgReject` is 0.
- R2: A `cfgLoad` pulse with a valid setting takes effect at the next edge. Endpoint e gets depth code `cfgDepth[3e+2:3e]` (0 to 4) and buffers base(e) to base(e)+depth-1, where base(e) is the sum of the depths of endpoints below e. All its chain positions and counts are cleared. Commit and release strobes in a `cfgLoad` cycle are ignored.
- R3: A setting whose depth codes sum to more than 8, or that holds any code above 4, is rejected. The previous configuration and state stay unchanged, and `cfgReject` is 1 for exactly the cycle after the load.
- R4: `cfgDir[e]`=0 makes the USB domain the producer, so `usbCommit` commits and `ioRelease` releases. `cfgDir[e]`=1 makes the I/O domain the producer, so `ioCommit` commits and `usbRelease` releases. Strobes from the other pair have no effect.
- R5: An accepted commit advances the producer's position one step round-robin within the chain, from depth-1 back to 0, at the next edge. The producer-side index is base(e)+position.
- R6: An accepted release advances the consumer's position the same way. The consumer-side index is base(e)+position, so buffers are released in commit order. `usbBufIdx` shows the producer index when `cfgDir[e]`=0 and the consumer index when it is 1. `ioBufIdx` shows the other one.
- R7: `bufIoOwned[b]` is 1 when the I/O domain holds buffer b. A committed, unreleased buffer belongs to the consumer. Any other buffer in a chain belongs to the producer. A buffer outside every chain reads 0.
- R8: `epEmpty[e]` is 1 when endpoint e holds no committed buffer. `epFull[e]` is 1 when every buffer in its chain is committed.
- R9: A commit to a full endpoint and a release from an empty endpoint are ignored.
- R10: A commit and a release in the same cycle on an endpoint that is neither empty nor full are both applied, and the count is unchanged.
- R11: An endpoint of depth 0 owns no buffers, shows 1 on both `epEmpty` and `epFull`, shows index 0 on both sides and ignores all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load a new configuration |
| cfgDepth | input | 12 | Depth code per endpoint, 3 bits each |
| cfgDir | input | 4 | Producer per endpoint: 0 USB, 1 I/O |
| usbCommit | input | 4 | USB-side commit strobe per endpoint |
| usbRelease | input | 4 | USB-side release strobe per endpoint |
| ioCommit | input | 4 | I/O-side commit strobe per endpoint |
| ioRelease | input | 4 | I/O-side release strobe per endpoint |
| usbBufIdx | output | 12 | Buffer index the USB side addresses, 3 bits per endpoint |
| ioBufIdx | output | 12 | Buffer index the I/O side addresses, 3 bits per endpoint |
| epEmpty | output | 4 | Endpoint holds no committed buffer |
| epFull | output | 4 | Every buffer of the endpoint is committed |
| bufIoOwned | output | 8 | Buffer currently held by the I/O domain |
| cfgReject | output | 1 | Previous configuration load was rejected |

## Verification
Random strobes on all four domain inputs are driven over several accepted configurations: a full eight-buffer mix of directions, layouts that include depth-0 endpoints, and all-single chains. This separates wrong-direction filtering from real handovers, and wraparound at each chain length from base-offset errors. Directed runs fill a chain past full, drain it past empty and pair a commit with a release. These show the ignore rules apart from the both-applied rule. Configurations over the budget, and configurations with an out-of-range code, are mixed in to show that rejection leaves all endpoint state intact.

// File: rtl/bufsw_pkg.sv
package bufsw_pkg;
  parameter int EP_COUNT  = 4;
  parameter int BUF_COUNT = 8;
  parameter int MAX_CHAIN = 4;

  localparam int IDX_W   = $clog2(BUF_COUNT);
  localparam int PTR_W   = $clog2(MAX_CHAIN);
  localparam int DEPTH_W = $clog2(MAX_CHAIN + 1);
  localparam int SUM_W   = $clog2(EP_COUNT * ((1 << DEPTH_W) - 1) + 1);

  typedef struct packed {
    logic [EP_COUNT-1:0] advWr;
    logic [EP_COUNT-1:0] advRd;
    logic                takeCfg;
    logic                rejectCfg;
  } swStrobe_t;
endpackage

// File: rtl/bufsw_ctrl.sv
module bufsw_ctrl
  import bufsw_pkg::*;
(
  input  logic                        cfgLoad,
  input  logic [EP_COUNT*DEPTH_W-1:0] cfgDepth,
  input  logic [EP_COUNT-1:0]         usbCommit,
  input  logic [EP_COUNT-1:0]         usbRelease,
  input  logic [EP_COUNT-1:0]         ioCommit,
  input  logic [EP_COUNT-1:0]         ioRelease,
  input  logic [EP_COUNT-1:0]         dirQ,
  input  logic [EP_COUNT-1:0]         epEmpty,
  input  logic [EP_COUNT-1:0]         epFull,
  output swStrobe_t                   strobe
);
  logic [SUM_W-1:0] total;
  logic             codeBad;

  always_comb begin
    total   = '0;
    codeBad = 1'b0;
    for (int e = 0; e < EP_COUNT; e++) begin
      total = total + SUM_W'(cfgDepth[e*DEPTH_W +: DEPTH_W]);
      if (int'(cfgDepth[e*DEPTH_W +: DEPTH_W]) > MAX_CHAIN) codeBad = 1'b1;
    end
  end

  always_comb begin
    strobe.takeCfg   = cfgLoad && !codeBad && (int'(total) <= BUF_COUNT);
    strobe.rejectCfg = cfgLoad && !strobe.takeCfg;
    for (int e = 0; e < EP_COUNT; e++) begin
      // the direction bit picks which domain produces and which consumes
      strobe.advWr[e] = !cfgLoad && !epFull[e]
                        && (dirQ[e] ? ioCommit[e] : usbCommit[e]);
      strobe.advRd[e] = !cfgLoad && !epEmpty[e]
                        && (dirQ[e] ? usbRelease[e] : ioRelease[e]);
    end
  end
endmodule

// File: rtl/bufsw_dp.sv
module bufsw_dp
  import bufsw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  swStrobe_t                   strobe,
  input  logic [EP_COUNT*DEPTH_W-1:0] cfgDepth,
  input  logic [EP_COUNT-1:0]         cfgDir,
  output logic [EP_COUNT-1:0]         dirQ,
  output logic [EP_COUNT-1:0]         epEmpty,
  output logic [EP_COUNT-1:0]         epFull,
  output logic [EP_COUNT*IDX_W-1:0]   usbBufIdx,
  output logic [EP_COUNT*IDX_W-1:0]   ioBufIdx,
  output logic [BUF_COUNT-1:0]        bufIoOwned,
  output logic                        cfgReject
);
  logic [DEPTH_W-1:0] depthQ [EP_COUNT];
  logic [DEPTH_W-1:0] cntQ   [EP_COUNT];
  logic [PTR_W-1:0]   wrPtr  [EP_COUNT];
  logic [PTR_W-1:0]   rdPtr  [EP_COUNT];
  logic [IDX_W-1:0]   wrIdx  [EP_COUNT];
  logic [IDX_W-1:0]   rdIdx  [EP_COUNT];
  int                 baseArr[EP_COUNT];

  function automatic logic [PTR_W-1:0] stepPtr(logic [PTR_W-1:0] p, logic [DEPTH_W-1:0] d);
    return (DEPTH_W'(p) + DEPTH_W'(1) >= d) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReject <= 1'b0;
      dirQ      <= '0;
      for (int e = 0; e < EP_COUNT; e++) begin
        depthQ[e] <= '0; cntQ[e] <= '0; wrPtr[e] <= '0; rdPtr[e] <= '0;
      end
    end else begin
      cfgReject <= strobe.rejectCfg;
      if (strobe.takeCfg) begin
        dirQ <= cfgDir;
        for (int e = 0; e < EP_COUNT; e++) begin
          depthQ[e] <= cfgDepth[e*DEPTH_W +: DEPTH_W];
          cntQ[e] <= '0; wrPtr[e] <= '0; rdPtr[e] <= '0;
        end
      end else begin
        for (int e = 0; e < EP_COUNT; e++) begin
          if (strobe.advWr[e]) wrPtr[e] <= stepPtr(wrPtr[e], depthQ[e]);
          if (strobe.advRd[e]) rdPtr[e] <= stepPtr(rdPtr[e], depthQ[e]);
          cntQ[e] <= cntQ[e] + DEPTH_W'(strobe.advWr[e]) - DEPTH_W'(strobe.advRd[e]);
        end
      end
    end
  end

  always_comb begin
    for (int e = 0; e < EP_COUNT; e++) begin
      baseArr[e] = (e == 0) ? 0 : baseArr[e-1] + int'(depthQ[e-1]);
      epEmpty[e] = (cntQ[e] == '0);
      epFull[e]  = (cntQ[e] == depthQ[e]);
      wrIdx[e]   = (depthQ[e] == '0) ? '0 : IDX_W'(baseArr[e] + int'(wrPtr[e]));
      rdIdx[e]   = (depthQ[e] == '0) ? '0 : IDX_W'(baseArr[e] + int'(rdPtr[e]));
      usbBufIdx[e*IDX_W +: IDX_W] = dirQ[e] ? rdIdx[e] : wrIdx[e];
      ioBufIdx[e*IDX_W +: IDX_W]  = dirQ[e] ? wrIdx[e] : rdIdx[e];
    end
  end

  // a chain slot is committed when its distance from the consumer position is below the count
  always_comb begin
    bufIoOwned = '0;
    for (int e = 0; e < EP_COUNT; e++) begin
      for (int k = 0; k < MAX_CHAIN; k++) begin
        if (k < int'(depthQ[e]) && baseArr[e] + k < BUF_COUNT) begin
          bufIoOwned[IDX_W'(baseArr[e] + k)] = dirQ[e] ^
            (((k >= int'(rdPtr[e])) ? k - int'(rdPtr[e])
                                    : k + int'(depthQ[e]) - int'(rdPtr[e])) < int'(cntQ[e]));
        end
      end
    end
  end
endmodule

// File: rtl/bufsw_top.sv
module bufsw_top
  import bufsw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgLoad,
  input  logic [EP_COUNT*DEPTH_W-1:0] cfgDepth,
  input  logic [EP_COUNT-1:0]         cfgDir,
  input  logic [EP_COUNT-1:0]         usbCommit,
  input  logic [EP_COUNT-1:0]         usbRelease,
  input  logic [EP_COUNT-1:0]         ioCommit,
  input  logic [EP_COUNT-1:0]         ioRelease,
  output logic [EP_COUNT*IDX_W-1:0]   usbBufIdx,
  output logic [EP_COUNT*IDX_W-1:0]   ioBufIdx,
  output logic [EP_COUNT-1:0]         epEmpty,
  output logic [EP_COUNT-1:0]         epFull,
  output logic [BUF_COUNT-1:0]        bufIoOwned,
  output logic                        cfgReject
);
  swStrobe_t           strobe;
  logic [EP_COUNT-1:0] dirQ;

  bufsw_ctrl u_ctrl (
    .cfgLoad(cfgLoad), .cfgDepth(cfgDepth),
    .usbCommit(usbCommit), .usbRelease(usbRelease),
    .ioCommit(ioCommit), .ioRelease(ioRelease),
    .dirQ(dirQ), .epEmpty(epEmpty), .epFull(epFull), .strobe(strobe)
  );

  bufsw_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgDepth(cfgDepth), .cfgDir(cfgDir),
    .dirQ(dirQ), .epEmpty(epEmpty), .epFull(epFull),
    .usbBufIdx(usbBufIdx), .ioBufIdx(ioBufIdx),
    .bufIoOwned(bufIoOwned), .cfgReject(cfgReject)
  );
endmodule

// File: rtl/bufsw_chk.sv
module bufsw_chk
  import bufsw_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        cfgLoad,
  input logic [EP_COUNT*DEPTH_W-1:0] cfgDepth,
  input logic [EP_COUNT-1:0]         usbCommit,
  input logic [EP_COUNT-1:0]         usbRelease,
  input logic [EP_COUNT-1:0]         ioCommit,
  input logic [EP_COUNT-1:0]         ioRelease,
  input logic [EP_COUNT-1:0]         dirQ,
  input logic [EP_COUNT-1:0]         epEmpty,
  input logic [EP_COUNT-1:0]         epFull,
  input logic                        cfgReject
);
  function automatic logic overBudget(logic [EP_COUNT*DEPTH_W-1:0] d);
    int s = 0;
    logic bad = 1'b0;
    for (int e = 0; e < EP_COUNT; e++) begin
      s += int'(d[e*DEPTH_W +: DEPTH_W]);
      if (int'(d[e*DEPTH_W +: DEPTH_W]) > MAX_CHAIN) bad = 1'b1;
    end
    return bad || (s > BUF_COUNT);
  endfunction

  // R3: an invalid load raises the reject flag at the next edge
  a_r3_reject_flag: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad && overBudget(cfgDepth) |=> cfgReject);

  // R3: a rejected load leaves the directions untouched
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    cfgReject |-> $stable(dirQ));

  for (genvar e = 0; e < EP_COUNT; e++) begin : g_ep
    logic prodC, consR;
    assign prodC = dirQ[e] ? ioCommit[e] : usbCommit[e];
    assign consR = dirQ[e] ? usbRelease[e] : ioRelease[e];

    // R8: an empty endpoint stays empty without a producer commit
    a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
      epEmpty[e] && !cfgLoad && !prodC |=> epEmpty[e]);

    // R9: a full endpoint stays full without a consumer release
    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rstN)
      epFull[e] && !cfgLoad && !consR |=> epFull[e]);

    // R10: paired commit and release keep the fill level
    a_r10_pair: assert property (@(posedge clk) disable iff (!rstN)
      !epEmpty[e] && !epFull[e] && prodC && consR && !cfgLoad
      |=> !epEmpty[e] && !epFull[e]);
  end
endmodule

bind bufsw_top bufsw_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDepth(cfgDepth),
  .usbCommit(usbCommit), .usbRelease(usbRelease),
  .ioCommit(ioCommit), .ioRelease(ioRelease),
  .dirQ(dirQ), .epEmpty(epEmpty), .epFull(epFull), .cfgReject(cfgReject)
);

// File: tb/sim_bufsw_top.sv
module sim_bufsw_top;
  localparam int NE = 4;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [NE*3-1:0] cfgDepth = '0;
  logic [NE-1:0] cfgDir = '0, usbCommit = '0, usbRelease = '0, ioCommit = '0, ioRelease = '0;
  logic [NE*3-1:0] usbBufIdx, ioBufIdx;
  logic [NE-1:0] epEmpty, epFull;
  logic [NB-1:0] bufIoOwned;
  logic cfgReject;

  int checks = 0, errors = 0;
  int mDepth[NE], mDir[NE], mWr[NE], mRd[NE], mCnt[NE];
  bit mRej = 0;
  string tag = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  bufsw_top u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDepth(cfgDepth), .cfgDir(cfgDir),
    .usbCommit(usbCommit), .usbRelease(usbRelease), .ioCommit(ioCommit), .ioRelease(ioRelease),
    .usbBufIdx(usbBufIdx), .ioBufIdx(ioBufIdx), .epEmpty(epEmpty), .epFull(epFull),
    .bufIoOwned(bufIoOwned), .cfgReject(cfgReject)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit cfgValid(logic [NE*3-1:0] d);
    int s = 0;
    for (int e = 0; e < NE; e++) begin
      if (d[e*3 +: 3] > 3'd4) return 0;
      s += int'(d[e*3 +: 3]);
    end
    return s <= NB;
  endfunction

  task automatic checkAll();
    int base = 0;
    logic [NB-1:0] own = '0;
    for (int e = 0; e < NE; e++) begin
      int wi = (mDepth[e] == 0) ? 0 : base + mWr[e];
      int ri = (mDepth[e] == 0) ? 0 : base + mRd[e];
      chk($sformatf("R8 empty ep%0d", e), int'(epEmpty[e]), int'(mCnt[e] == 0));
      chk($sformatf("R8 full ep%0d", e), int'(epFull[e]), int'(mCnt[e] == mDepth[e]));
      chk($sformatf("R5 R6 usbIdx ep%0d", e), int'(usbBufIdx[e*3 +: 3]), mDir[e] ? ri : wi);
      chk($sformatf("R5 R6 ioIdx ep%0d", e), int'(ioBufIdx[e*3 +: 3]), mDir[e] ? wi : ri);
      for (int k = 0; k < mDepth[e]; k++) begin
        int rel = (k - mRd[e] + mDepth[e]) % mDepth[e];
        own[base + k] = (rel < mCnt[e]) ^ (mDir[e] != 0);
      end
      base += mDepth[e];
    end
    chk("R7 ownership", int'(bufIoOwned), int'(own));
    chk("R3 reject flag", int'(cfgReject), int'(mRej));
  endtask

  // one cycle: check current outputs, drive inputs, advance the model
  task automatic step(bit ld, logic [NE*3-1:0] d, logic [NE-1:0] dr,
                      logic [NE-1:0] uc, logic [NE-1:0] ur, logic [NE-1:0] ic, logic [NE-1:0] ir);
    @(negedge clk);
    checkAll();
    cfgLoad = ld; cfgDepth = d; cfgDir = dr;
    usbCommit = uc; usbRelease = ur; ioCommit = ic; ioRelease = ir;
    mRej = ld && !cfgValid(d);
    if (ld) begin
      if (cfgValid(d))
        for (int e = 0; e < NE; e++) begin
          mDepth[e] = int'(d[e*3 +: 3]); mDir[e] = int'(dr[e]);
          mWr[e] = 0; mRd[e] = 0; mCnt[e] = 0;
        end
    end else begin
      for (int e = 0; e < NE; e++) begin
        bit p = mDir[e] ? ic[e] : uc[e];
        bit c = mDir[e] ? ur[e] : ir[e];
        bit aw = p && (mCnt[e] < mDepth[e]);
        bit ar = c && (mCnt[e] > 0);
        if (aw) begin mWr[e] = (mWr[e] + 1) % mDepth[e]; mCnt[e]++; end
        if (ar) begin mRd[e] = (mRd[e] + 1) % mDepth[e]; mCnt[e]--; end
      end
    end
  endtask

  task automatic idle();
    step(0, cfgDepth, cfgDir, '0, '0, '0, '0);
  endtask

  task automatic loadCfg(int d0, int d1, int d2, int d3, logic [NE-1:0] dr);
    step(1, {3'(d3), 3'(d2), 3'(d1), 3'(d0)}, dr, '0, '0, '0, '0);
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++)
      step(0, cfgDepth, cfgDir, NE'($urandom), NE'($urandom), NE'($urandom), NE'($urandom));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < NE; e++) begin mDepth[e] = 0; mDir[e] = 0; mWr[e] = 0; mRd[e] = 0; mCnt[e] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tag = "R1"; idle();

    tag = "R2"; loadCfg(4, 2, 1, 1, 4'b1010); idle();
    tag = "R4";  // wrong-side strobes only: ep0 usb producer, ep1 io producer
    step(0, cfgDepth, cfgDir, 4'b0010, 4'b0001, 4'b0001, 4'b0010); idle();
    tag = "R9";
    for (int i = 0; i < 6; i++) step(0, cfgDepth, cfgDir, 4'b0001, '0, '0, '0);
    idle();
    tag = "R10";
    step(0, cfgDepth, cfgDir, '0, '0, '0, 4'b0001);
    step(0, cfgDepth, cfgDir, 4'b0001, '0, '0, 4'b0001); idle();
    tag = "R6";
    for (int i = 0; i < 6; i++) step(0, cfgDepth, cfgDir, '0, '0, '0, 4'b0001);
    idle();
    tag = "R5"; randomRun(600);

    tag = "R3"; loadCfg(4, 4, 1, 0, 4'b0000); idle();
    loadCfg(5, 0, 0, 0, 4'b1111); idle();
    randomRun(100);

    tag = "R11"; loadCfg(3, 0, 2, 3, 4'b0101); idle();
    for (int i = 0; i < 4; i++) step(0, cfgDepth, cfgDir, 4'b0010, 4'b0010, 4'b0010, 4'b0010);
    randomRun(500);

    tag = "R2"; loadCfg(1, 1, 1, 1, 4'b0110); randomRun(400);

    tag = "R7";
    for (int i = 0; i < 20; i++) begin
      step(1, NE*3'($urandom), NE'($urandom), '0, '0, '0, '0);
      randomRun(100);
    end
    idle();
    finish();
  end
endmodule